// File: doc/BRIEF.md
# Serial Attenuator Frame Programmer

This block is the host-side driver for an addressable digital step attenuator that is programmed over a three-wire link: serial data, serial clock and latch. A request carries an attenuation value in quarter-dB units and a 3-bit target address. The block turns the request into a 16-bit frame and shifts the frame out one bit per serial clock period. It then pulses the latch line to commit the frame and signals completion.

The serial clock is made from the system clock. The low and high phase lengths, the gap between the last clock edge and the latch, and the latch pulse width are each a parameter counted in system-clock cycles. At 125 MHz the defaults give a serial clock of 104 ns, with phases of 56 ns and 48 ns, a 16 ns wait before the latch and a 32 ns latch pulse. These defaults respect the link limits: a clock no faster than 10 MHz, phases of at least 30 ns, data setup and hold of at least 10 ns, a 10 ns wait from the last rising edge to the latch, and a latch at least 30 ns wide. Data changes only when the serial clock falls, so each bit stays stable across the rising edge on which it is sampled.

A request is taken when `start_i` is high and the block is idle. Requests that arrive while a transfer is running are dropped. Values above 127 quarter-dB are clamped to 127, and a flag output reports that the value was clamped.

Top module: `atten_frame_prog`

## Requirements
- R1: The attenuation byte is min(value, 127) in its low 7 bits, and its bit 7 is always 0. For example, value 73 (18.25 dB) gives byte 0x49.
- R2: The frame is 16 bits and is sent least significant bit first. Frame bits 7:0 are the attenuation byte. Frame bits 10:8 are the address. Frame bits 15:11 are sent as 0.
- R3: The latch stays low while the 16 bits are shifted. After the 16th rising edge and the setup gap, the latch goes high for exactly LE_PULSE_CYC system cycles, and the serial clock stays low during that time.
- R4: Within a frame, every serial clock low phase before a rising edge lasts exactly CLK_LO_CYC system cycles, and every high phase lasts exactly CLK_HI_CYC cycles.
- R5: Serial data does not change while the serial clock is high, and does not change in the cycle in which the clock rises.
- R6: The latch rises exactly CLK_HI_CYC + LE_SETUP_CYC system cycles after the last rising edge of the serial clock.
- R7: `busy_o` is high from the cycle after an accepted start until the transfer ends. `done_o` is a one-cycle pulse in the cycle in which the latch returns low, and `busy_o` is already low in that cycle.
- R8: A start that arrives while busy (including the final latch cycle) is ignored: it produces no frame and does not change `clamp_o`. A start that arrives in the `done_o` cycle is accepted.
- R9: `clamp_o` is 1 when the last accepted value was above 127 and 0 otherwise. It holds until the next accepted request.
- R10: In reset and right after it, the serial clock, serial data, latch, `busy_o`, `done_o` and `clamp_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| atten_qdb_i | input | IN_W | Attenuation in quarter-dB units |
| addr_i | input | ADDR_W | Target attenuator address |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| clamp_o | output | 1 | Last accepted value was clamped |
| ser_clk_o | output | 1 | Serial clock to the attenuator |
| ser_data_o | output | 1 | Serial data to the attenuator |
| latch_o | output | 1 | Latch strobe to the attenuator |

## Verification
Two pairs of events can fall in the same cycle. In the first, the completion pulse and a new start coincide: the driver raises start in the very cycle in which `done_o` is seen, and the scoreboard expects a second, complete frame with no idle cycle in between. In the second, the final latch cycle and a start coincide: the driver raises start while the latch is in its last high cycle, and the checks expect no extra frame, no change to `clamp_o`, and the block to stay idle afterwards.

// File: rtl/atten_prog_pkg.sv
package atten_prog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_SETUP,
    ST_LATCH
  } seq_state_e;
endpackage

// File: rtl/atten_frame_build.sv
module atten_frame_build #(
  parameter int IN_W   = 8,
  parameter int WORD_W = 8,
  parameter int ADDR_W = 3,
  localparam int FRAME_W  = 2 * WORD_W,
  localparam int MAX_CODE = (1 << (WORD_W - 1)) - 1
) (
  input  logic [IN_W-1:0]    atten_qdb_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               clamp_o
);
  logic [WORD_W-2:0] code;

  always_comb begin
    clamp_o = (32'(atten_qdb_i) > MAX_CODE);
    code    = clamp_o ? (WORD_W-1)'(MAX_CODE) : atten_qdb_i[WORD_W-2:0];
    // top bit of each word is driven low
    frame_o = {{(WORD_W-ADDR_W){1'b0}}, addr_i, 1'b0, code};
  end
endmodule

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire_o = (cnt_q == '0);

  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0)); // R4
endmodule

// File: rtl/atten_shifter.sv
module atten_shifter #(
  parameter int FRAME_W = 16,
  localparam int BCNT_W = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               data_o,
  output logic               last_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [BCNT_W-1:0]  bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bcnt_q <= '0;
    end else if (load_i) begin
      sh_q   <= frame_i;
      bcnt_q <= '0;
    end else if (shift_i) begin
      sh_q   <= sh_q >> 1;
      bcnt_q <= bcnt_q + BCNT_W'(1);
    end
  end

  assign data_o = sh_q[0];
  assign last_o = (bcnt_q == BCNT_W'(FRAME_W - 1));

  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i)); // R2
endmodule

// File: rtl/atten_frame_prog.sv
module atten_frame_prog
  import atten_prog_pkg::*;
#(
  parameter int IN_W         = 8,
  parameter int ADDR_W       = 3,
  parameter int WORD_W       = 8,
  parameter int CLK_LO_CYC   = 7,
  parameter int CLK_HI_CYC   = 6,
  parameter int LE_SETUP_CYC = 2,
  parameter int LE_PULSE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IN_W-1:0]   atten_qdb_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              clamp_o,
  output logic              ser_clk_o,
  output logic              ser_data_o,
  output logic              latch_o
);
  localparam int FRAME_W = 2 * WORD_W;
  localparam int MAX_A   = (CLK_LO_CYC > CLK_HI_CYC) ? CLK_LO_CYC : CLK_HI_CYC;
  localparam int MAX_B   = (LE_SETUP_CYC > LE_PULSE_CYC) ? LE_SETUP_CYC : LE_PULSE_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e         state_q, state_d;
  logic [FRAME_W-1:0] frame;
  logic               clamp_now;
  logic               t_load, t_exp;
  logic [CNT_W-1:0]   t_len;
  logic               sh_load, sh_shift, sh_last;
  logic               sclk_q, latch_q, done_q, clamp_q;

  atten_frame_build #(.IN_W(IN_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_build (
    .atten_qdb_i (atten_qdb_i),
    .addr_i      (addr_i),
    .frame_o     (frame),
    .clamp_o     (clamp_now)
  );

  atten_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (t_load),
    .len_i    (t_len),
    .expire_o (t_exp)
  );

  atten_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .shift_i (sh_shift),
    .frame_i (frame),
    .data_o  (ser_data_o),
    .last_o  (sh_last)
  );

  always_comb begin
    state_d  = state_q;
    t_load   = 1'b0;
    t_len    = CNT_W'(CLK_LO_CYC);
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_LOW;
        t_load  = 1'b1;
        sh_load = 1'b1;
      end
      ST_LOW: if (t_exp) begin
        state_d = ST_HIGH;
        t_load  = 1'b1;
        t_len   = CNT_W'(CLK_HI_CYC);
      end
      ST_HIGH: if (t_exp) begin
        // data moves on the falling serial edge
        sh_shift = 1'b1;
        t_load   = 1'b1;
        if (sh_last) begin
          state_d = ST_SETUP;
          t_len   = CNT_W'(LE_SETUP_CYC);
        end else begin
          state_d = ST_LOW;
        end
      end
      ST_SETUP: if (t_exp) begin
        state_d = ST_LATCH;
        t_load  = 1'b1;
        t_len   = CNT_W'(LE_PULSE_CYC);
      end
      ST_LATCH: if (t_exp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      latch_q <= 1'b0;
      done_q  <= 1'b0;
      clamp_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= (state_d == ST_HIGH);
      latch_q <= (state_d == ST_LATCH);
      done_q  <= (state_q == ST_LATCH) && (state_d == ST_IDLE);
      if (sh_load) clamp_q <= clamp_now;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign clamp_o   = clamp_q;
  assign ser_clk_o = sclk_q;
  assign latch_o   = latch_q;

  AST_LATCH_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> !ser_clk_o); // R3
  AST_SI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o)); // R5
  AST_SI_SETUP_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_clk_o) |-> $stable(ser_data_o)); // R5
  AST_DONE_AFTER_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!latch_o && $past(latch_o) && !busy_o)); // R7
  AST_IGNORE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(clamp_o)); // R8
  AST_CLK_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_clk_o || latch_o) |-> busy_o); // R7
endmodule

// File: tb/atten_frame_prog_test.sv
module atten_frame_prog_test;
  localparam int LO = 7, HI = 6, SU = 2, PW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] val = '0;
  logic [2:0] addr = '0;
  logic       busy, done, clamp, sclk, sdata, latch;

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [15:0] exp_frame[$];
  logic        exp_clamp[$];
  int          n_pushed = 0, n_seen = 0;
  bit          mon_en = 1'b0;

  always #4 clk = ~clk;

  atten_frame_prog #(.CLK_LO_CYC(LO), .CLK_HI_CYC(HI),
                     .LE_SETUP_CYC(SU), .LE_PULSE_CYC(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .atten_qdb_i(val),
    .addr_i(addr), .busy_o(busy), .done_o(done), .clamp_o(clamp),
    .ser_clk_o(sclk), .ser_data_o(sdata), .latch_o(latch)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [7:0] v, input logic [2:0] a);
    logic [6:0] c;
    c = (v > 8'd127) ? 7'd127 : v[6:0];
    return {5'b0, a, 1'b0, c};
  endfunction

  // driver: waits for idle, strobes one cycle, pushes expectation
  task automatic send(input logic [7:0] v, input logic [2:0] a);
    do @(negedge clk); while (busy);
    val = v; addr = a; start = 1'b1;
    exp_frame.push_back(model(v, a));
    exp_clamp.push_back(v > 8'd127);
    n_pushed++;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after start", busy, 1);
  endtask

  // monitor
  logic        p_s = 0, p_d = 0, p_l = 0;
  int          run = 0, since_rise = 0, lat_run = 0, nbits = 0;
  logic [15:0] got;
  always @(negedge clk) begin
    if (mon_en) begin
      since_rise++;
      if (sclk && !p_s) begin
        if (nbits > 0) chk("R4 low phase", run, LO);
        chk("R5 data at rise", sdata, p_d);
        chk("R3 latch low while shifting", latch, 0);
        if (nbits < 16) got[nbits] = sdata;
        nbits++;
        since_rise = 0;
      end
      if (!sclk && p_s) chk("R4 high phase", run, HI);
      if (sclk && p_s && sdata != p_d) chk("R5 data in high phase", sdata, p_d);
      run = (sclk == p_s) ? run + 1 : 1;
      if (latch && !p_l) begin
        chk("R6 last rise to latch", since_rise, HI + SU);
        chk("R3 bits before latch", nbits, 16);
        lat_run = 0;
      end
      if (latch) begin
        lat_run++;
        if (sclk) chk("R3 clock low in latch", sclk, 0);
      end
      if (!latch && p_l) begin
        chk("R3 latch width", lat_run, PW);
        chk("R7 done with latch fall", done, 1);
        chk("R7 busy low at done", busy, 0);
        n_seen++;
        if (exp_frame.size() == 0) chk("R8 unexpected frame", 1, 0);
        else begin
          logic [15:0] ef;
          logic        ec;
          ef = exp_frame.pop_front();
          ec = exp_clamp.pop_front();
          chk("R1 attenuation byte", got[7:0], ef[7:0]);
          chk("R2 address and upper bits", got[15:8], ef[15:8]);
          chk("R9 clamp flag", clamp, ec);
        end
        nbits = 0;
      end else if (done) chk("R7 stray done", done, 0);
      p_s = sclk; p_d = sdata; p_l = latch;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%0d expected<100000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset sclk", sclk, 0);
    chk("R10 reset sdata", sdata, 0);
    chk("R10 reset latch", latch, 0);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset clamp", clamp, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", {busy, sclk, latch, done}, 0);
    mon_en = 1'b1;

    send(8'd73, 3'd3);     // R1 18.25 dB -> 0x49
    send(8'd0, 3'd0);
    send(8'd127, 3'd7);
    send(8'd128, 3'd5);    // R9 clamp
    send(8'd255, 3'd2);    // R9 clamp, back-to-back in done cycle (R8)
    send(8'h55, 3'd6);     // R9 flag clears

    // R8: start during shifting is ignored
    repeat (40) @(negedge clk);
    val = 8'd200; addr = 3'd1; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    chk("R8 clamp kept during busy start", clamp, 0);

    // R8: start in the final latch cycle is ignored
    send(8'd10, 3'd4);
    do @(negedge clk); while (!latch);
    repeat (PW - 1) @(negedge clk);
    val = 8'd250; addr = 3'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 no transfer from latch-cycle start", busy, 0);
    chk("R8 clamp unchanged", clamp, 0);

    send(8'd1, 3'd1);
    send(8'd64, 3'd2);
    do @(negedge clk); while (busy);
    repeat (20) @(negedge clk);
    chk("R8 frame count", n_seen, n_pushed);
    chk("R8 queue drained", exp_frame.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule